// File: doc/BRIEF.md
# Nested Exception Escalation Unit

This block sits beside a processor's exception sequencer. It judges each newly raised exception against the one that is still being delivered. Some pairs cannot be handled one after the other: two faults from the contributory class, or a page fault followed by a contributory fault or a second page fault. For these pairs the unit replaces the new exception with a double fault and zeroes its error code. If any exception is raised while a double fault is in flight, the unit asks for a shutdown instead of giving a vector.

The unit holds a one-entry record of the exception in delivery. It keeps that record apart from an "empty" flag, so vector 0 is never mistaken for "nothing pending". The sequencer pulses a completion strobe when it has delivered an exception, and this clears the record. Software interrupt instructions pass straight through. They are not checked and they do not touch the record. The result is registered and appears one cycle after the raise strobe.

Top module: `exc_escalator`

## Requirements
- R1: While reset is held and after it is released, `res_valid_o` and `shutdown_o` are 0 and the record is empty.
- R2: A raise gives exactly one `res_valid_o` pulse in the next cycle. An exception that is not escalated comes out with its own vector and error code unchanged.
- R3: The contributory class is vectors 0, 10, 11, 12 and 13. A contributory exception raised while a contributory one is recorded becomes vector 8 with error code 0.
- R4: A contributory exception or a page fault (vector 14) raised while a page fault is recorded becomes vector 8 with error code 0. A page fault raised while a contributory exception is recorded stays vector 14 with its own error code.
- R5: A non-software raise while vector 8 is recorded sets `shutdown_o` in the next cycle, and `res_valid_o` stays 0.
- R6: The record takes the resulting vector only when that vector is contributory, 14 or 8. Any other result leaves the record unchanged.
- R7: A `deliver_done_i` pulse empties the record.
- R8: An empty record is distinct from a recorded vector 0. Vector 0 raised on an empty record is not escalated.
- R9: A raise with `swint_i` = 1 comes out unchanged, never escalates, never shuts down and leaves the record unchanged.
- R10: When `deliver_done_i` and a raise come in the same cycle, the raise is judged against an empty record, and its own record update still applies.
- R11: Once set, `shutdown_o` stays 1 until reset, and every later raise is dropped with no `res_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | 1 | Raise strobe, one cycle per exception |
| vec_i | input | VEC_W | Vector number of the raised exception |
| swint_i | input | 1 | Raise comes from a software interrupt instruction |
| err_i | input | ERR_W | Error code of the raised exception |
| deliver_done_i | input | 1 | Delivery of the recorded exception has finished |
| res_valid_o | output | 1 | One-cycle pulse: result fields valid |
| res_vec_o | output | VEC_W | Final vector |
| res_err_o | output | ERR_W | Final error code |
| shutdown_o | output | 1 | Sticky triple-fault shutdown request |

## Verification
A wrong record shows up only at the next raise that is not a software interrupt. Such a raise would give a double fault where the plain vector was due, or the reverse, or a shutdown where a vector was due. It always appears one cycle after that raise. The directed scenarios therefore set up a record, apply the stimulus under test (a benign raise, a software interrupt, a completion pulse), and then use a probing contributory raise to bring the record's contents out to the ports. A stuck or missed shutdown shows one cycle after the raise that follows a double fault.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;
    // Vector numbers the escalation rules decode
    parameter int unsigned VEC_DIVIDE = 0;
    parameter int unsigned VEC_DOUBLE = 8;
    parameter int unsigned CONTRIB_LO = 10;
    parameter int unsigned CONTRIB_HI = 13;
    parameter int unsigned VEC_PAGE   = 14;

    // Result classes of one exception
    typedef struct packed {
        logic contrib;
        logic page;
        logic dbl;
    } exc_class_t;
endpackage

// File: rtl/exc_class.sv
module exc_class
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec_i,
    output exc_class_t       cls_o
);
    localparam logic [VEC_W-1:0] V_DIV = VEC_W'(VEC_DIVIDE);
    localparam logic [VEC_W-1:0] V_LO  = VEC_W'(CONTRIB_LO);
    localparam logic [VEC_W-1:0] V_HI  = VEC_W'(CONTRIB_HI);
    localparam logic [VEC_W-1:0] V_PF  = VEC_W'(VEC_PAGE);
    localparam logic [VEC_W-1:0] V_DF  = VEC_W'(VEC_DOUBLE);

    always_comb begin
        cls_o.contrib = (vec_i == V_DIV) || ((vec_i >= V_LO) && (vec_i <= V_HI));
        cls_o.page    = (vec_i == V_PF);
        cls_o.dbl     = (vec_i == V_DF);
    end
endmodule

// File: rtl/exc_rule.sv
module exc_rule
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32
) (
    input  logic             rec_vld_i,
    input  logic [VEC_W-1:0] rec_vec_i,
    input  logic [VEC_W-1:0] new_vec_i,
    input  logic [ERR_W-1:0] new_err_i,
    output logic [VEC_W-1:0] res_vec_o,
    output logic [ERR_W-1:0] res_err_o,
    output logic             res_track_o,
    output logic             res_shutdown_o
);
    localparam logic [VEC_W-1:0] V_DF = VEC_W'(VEC_DOUBLE);

    exc_class_t rec_cls;
    exc_class_t new_cls;
    exc_class_t res_cls;
    logic       escalate;

    exc_class #(.VEC_W(VEC_W)) u_rec_cls (.vec_i(rec_vec_i), .cls_o(rec_cls));
    exc_class #(.VEC_W(VEC_W)) u_new_cls (.vec_i(new_vec_i), .cls_o(new_cls));
    exc_class #(.VEC_W(VEC_W)) u_res_cls (.vec_i(res_vec_o), .cls_o(res_cls));

    always_comb begin
        res_shutdown_o = rec_vld_i && rec_cls.dbl;
        escalate = rec_vld_i &&
                   ((rec_cls.contrib && new_cls.contrib) ||
                    (rec_cls.page && (new_cls.contrib || new_cls.page)));
        if (escalate) begin
            res_vec_o = V_DF;
            res_err_o = '0;
        end else begin
            res_vec_o = new_vec_i;
            res_err_o = new_err_i;
        end
        res_track_o = res_cls.contrib || res_cls.page || res_cls.dbl;
    end
endmodule

// File: rtl/exc_escalator.sv
module exc_escalator
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             swint_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic             deliver_done_i,
    output logic             res_valid_o,
    output logic [VEC_W-1:0] res_vec_o,
    output logic [ERR_W-1:0] res_err_o,
    output logic             shutdown_o
);
    typedef struct packed {
        logic             rec_vld;
        logic [VEC_W-1:0] rec_vec;
        logic             out_vld;
        logic [VEC_W-1:0] out_vec;
        logic [ERR_W-1:0] out_err;
        logic             sd;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    logic             eff_rec_vld;
    logic [VEC_W-1:0] rule_vec;
    logic [ERR_W-1:0] rule_err;
    logic             rule_track;
    logic             rule_sd;

    // A completion in the same cycle empties the record before judging
    assign eff_rec_vld = state_q.rec_vld && !deliver_done_i;

    exc_rule #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_rule (
        .rec_vld_i      (eff_rec_vld),
        .rec_vec_i      (state_q.rec_vec),
        .new_vec_i      (vec_i),
        .new_err_i      (err_i),
        .res_vec_o      (rule_vec),
        .res_err_o      (rule_err),
        .res_track_o    (rule_track),
        .res_shutdown_o (rule_sd)
    );

    always_comb begin
        state_d         = state_q;
        state_d.out_vld = 1'b0;
        if (deliver_done_i) begin
            state_d.rec_vld = 1'b0;
        end
        if (raise_i && !state_q.sd) begin
            if (swint_i) begin
                state_d.out_vld = 1'b1;
                state_d.out_vec = vec_i;
                state_d.out_err = err_i;
            end else if (rule_sd) begin
                state_d.sd = 1'b1;
            end else begin
                state_d.out_vld = 1'b1;
                state_d.out_vec = rule_vec;
                state_d.out_err = rule_err;
                if (rule_track) begin
                    state_d.rec_vld = 1'b1;
                    state_d.rec_vec = rule_vec;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid_o = state_q.out_vld;
    assign res_vec_o   = state_q.out_vec;
    assign res_err_o   = state_q.out_err;
    assign shutdown_o  = state_q.sd;
endmodule

// File: rtl/exc_escalator_chk.sv
module exc_escalator_chk #(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             raise_i,
    input logic [VEC_W-1:0] vec_i,
    input logic             swint_i,
    input logic [ERR_W-1:0] err_i,
    input logic             res_valid_o,
    input logic [VEC_W-1:0] res_vec_o,
    input logic [ERR_W-1:0] res_err_o,
    input logic             shutdown_o
);
    // R2
    valid_follows_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(raise_i));

    // R3
    escalated_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_vec_o == VEC_W'(8) && $past(vec_i) != VEC_W'(8)) |-> res_err_o == '0);

    // R9
    swint_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && $past(swint_i)) |-> (res_vec_o == $past(vec_i) && res_err_o == $past(err_i)));

    // R11
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |=> shutdown_o);

    // R5
    shutdown_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> !res_valid_o);

    // R5
    shutdown_needs_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_o) |-> ($past(raise_i) && !$past(swint_i)));
endmodule

bind exc_escalator exc_escalator_chk #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raise_i     (raise_i),
    .vec_i       (vec_i),
    .swint_i     (swint_i),
    .err_i       (err_i),
    .res_valid_o (res_valid_o),
    .res_vec_o   (res_vec_o),
    .res_err_o   (res_err_o),
    .shutdown_o  (shutdown_o)
);

// File: tb/exc_escalator_test.sv
module exc_escalator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_i = 1'b0;
    logic [7:0]  vec_i = '0;
    logic        swint_i = 1'b0;
    logic [31:0] err_i = '0;
    logic        deliver_done_i = 1'b0;
    logic        res_valid_o;
    logic [7:0]  res_vec_o;
    logic [31:0] res_err_o;
    logic        shutdown_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    exc_escalator uut (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .vec_i(vec_i),
        .swint_i(swint_i), .err_i(err_i), .deliver_done_i(deliver_done_i),
        .res_valid_o(res_valid_o), .res_vec_o(res_vec_o),
        .res_err_o(res_err_o), .shutdown_o(shutdown_o)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; raise_i = 1'b0; deliver_done_i = 1'b0; swint_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one raise (optionally with completion), check the registered result
    task automatic raise(string tag, logic [7:0] v, logic sw, logic [31:0] e, logic dn,
                         logic exp_vld, logic [7:0] exp_v, logic [31:0] exp_e, logic exp_sd);
        @(negedge clk);
        raise_i = 1'b1; vec_i = v; swint_i = sw; err_i = e; deliver_done_i = dn;
        @(negedge clk);
        raise_i = 1'b0; swint_i = 1'b0; deliver_done_i = 1'b0;
        check({tag, " valid"}, 64'(res_valid_o), 64'(exp_vld));
        if (exp_vld) begin
            check({tag, " vec"}, 64'(res_vec_o), 64'(exp_v));
            check({tag, " err"}, 64'(res_err_o), 64'(exp_e));
        end
        check({tag, " shutdown"}, 64'(shutdown_o), 64'(exp_sd));
    endtask

    task automatic complete();
        @(negedge clk);
        deliver_done_i = 1'b1;
        @(negedge clk);
        deliver_done_i = 1'b0;
        check("R7 no output on completion", 64'(res_valid_o), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid in reset", 64'(res_valid_o), 64'd0);
        check("R1 shutdown in reset", 64'(shutdown_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 64'(res_valid_o), 64'd0);
        check("R1 shutdown after reset", 64'(shutdown_o), 64'd0);
        raise("R1 empty record gives plain 13", 8'd13, 0, 32'h5, 0, 1, 8'd13, 32'h5, 0);
    endtask

    task automatic t_plain();
        do_reset();
        raise("R2 benign vector 3", 8'd3, 0, 32'hABCD, 0, 1, 8'd3, 32'hABCD, 0);
        @(negedge clk);
        check("R2 single pulse", 64'(res_valid_o), 64'd0);
    endtask

    task automatic t_contrib_pair();
        do_reset();
        raise("R3 first 13", 8'd13, 0, 32'h11, 0, 1, 8'd13, 32'h11, 0);
        raise("R3 then 0 escalates", 8'd0, 0, 32'h55, 0, 1, 8'd8, 32'h0, 0);
        raise("R5 raise on double fault", 8'd3, 0, 32'h1, 0, 0, 8'd0, 32'h0, 1);
        raise("R11 later raise dropped", 8'd13, 0, 32'h1, 0, 0, 8'd0, 32'h0, 1);
        raise("R11 swint dropped too", 8'd33, 1, 32'h1, 0, 0, 8'd0, 32'h0, 1);
        complete();
        check("R11 shutdown stays after completion", 64'(shutdown_o), 64'd1);
    endtask

    task automatic t_page();
        do_reset();
        raise("R4 first PF", 8'd14, 0, 32'h6, 0, 1, 8'd14, 32'h6, 0);
        raise("R4 PF after PF", 8'd14, 0, 32'h7, 0, 1, 8'd8, 32'h0, 0);
        do_reset();
        raise("R4 PF", 8'd14, 0, 32'h2, 0, 1, 8'd14, 32'h2, 0);
        raise("R4 contrib 11 after PF", 8'd11, 0, 32'h9, 0, 1, 8'd8, 32'h0, 0);
        do_reset();
        raise("R4 contrib 10", 8'd10, 0, 32'h3, 0, 1, 8'd10, 32'h3, 0);
        raise("R4 PF after contrib stays", 8'd14, 0, 32'h4, 0, 1, 8'd14, 32'h4, 0);
        raise("R6 record now PF", 8'd14, 0, 32'h4, 0, 1, 8'd8, 32'h0, 0);
    endtask

    task automatic t_benign_keeps();
        do_reset();
        raise("R6 record 13", 8'd13, 0, 32'h1, 0, 1, 8'd13, 32'h1, 0);
        raise("R6 benign 3 after 13", 8'd3, 0, 32'h2, 0, 1, 8'd3, 32'h2, 0);
        raise("R6 record still 13", 8'd0, 0, 32'h3, 0, 1, 8'd8, 32'h0, 0);
    endtask

    task automatic t_complete();
        do_reset();
        raise("R7 record 12", 8'd12, 0, 32'h1, 0, 1, 8'd12, 32'h1, 0);
        complete();
        raise("R7 0 after completion", 8'd0, 0, 32'h3, 0, 1, 8'd0, 32'h3, 0);
    endtask

    task automatic t_zero();
        do_reset();
        raise("R8 vector 0 on empty", 8'd0, 0, 32'h8, 0, 1, 8'd0, 32'h8, 0);
        raise("R8 vector 0 after 0", 8'd0, 0, 32'h8, 0, 1, 8'd8, 32'h0, 0);
    endtask

    task automatic t_swint();
        do_reset();
        raise("R9 record 13", 8'd13, 0, 32'h1, 0, 1, 8'd13, 32'h1, 0);
        raise("R9 swint 13 no escalation", 8'd13, 1, 32'h77, 0, 1, 8'd13, 32'h77, 0);
        raise("R9 swint 14 no record change", 8'd14, 1, 32'h0, 0, 1, 8'd14, 32'h0, 0);
        raise("R9 record still 13", 8'd0, 0, 32'h3, 0, 1, 8'd8, 32'h0, 0);
        raise("R9 swint on double fault", 8'd0, 1, 32'h9, 0, 1, 8'd0, 32'h9, 0);
        check("R9 no shutdown from swint", 64'(shutdown_o), 64'd0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        raise("R10 record 13", 8'd13, 0, 32'h1, 0, 1, 8'd13, 32'h1, 0);
        raise("R10 raise 0 with completion", 8'd0, 0, 32'h4, 1, 1, 8'd0, 32'h4, 0);
        raise("R10 own update kept", 8'd10, 0, 32'h5, 0, 1, 8'd8, 32'h0, 0);
    endtask

    task automatic t_direct_df();
        do_reset();
        raise("R2 direct 8 keeps err", 8'd8, 0, 32'h9, 0, 1, 8'd8, 32'h9, 0);
        raise("R6 8 recorded then shutdown", 8'd5, 0, 32'h1, 0, 0, 8'd0, 32'h0, 1);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_contrib_pair();
        t_page();
        t_benign_keeps();
        t_complete();
        t_zero();
        t_swint();
        t_same_cycle();
        t_direct_df();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule